// File: doc/BRIEF.md
# Signal voltage switch sequencer

This block is the hardware sequencer an SD host controller uses to move the card's signalling level between 3.3 V and 1.8 V. A requester pulses `start_i` with the level it wants in `req_18v_i`. The sequencer then works through the switch using three outputs: the 1.8 V signal-enable bit to the regulator, the card clock enable and bus power. It makes its decisions from two inputs. One is the regulator's readback of the enable bit. The other is the level of the four DAT lines.

Every wait in the sequence comes from one down-counter. Its length is set by the parameter `CYCLES_PER_MS`, which gives the clock cycles per millisecond, so simulation can use small intervals. When a wait ends, the sampled inputs are first registered in one cycle and judged in the next.

A 1.8 V attempt can fail at any step. In that case the card is power-cycled and the sequencer returns a retry code. The retry code tells the requester to initialise the card again without asking for 1.8 V.

Top module: `vsw_sequencer`

## Requirements
- R1: While reset is asserted, and right after it, the outputs are: `sig18_en_o`=0, `card_clk_en_o`=1, `bus_pwr_o`=1, `busy_o`=0, `done_o`=0 and `result_o`=00.
- R2: If `ver3_i`=0 when a start is accepted, `done_o` rises on that same clock edge with result 00. `sig18_en_o`, `card_clk_en_o` and `bus_pwr_o` do not change.
- R3: A 3.3 V request (`req_18v_i`=0) clears `sig18_en_o` on the edge that accepts it. After 5 ms of cycles the readback is captured. Done rises 5·CYCLES_PER_MS+2 edges after the accepting edge. The result is 00 if the readback was 0 and 01 (I/O error) if it was 1.
- R4: A 1.8 V request made while `sig18_en_o` is already 1 completes on the accepting edge with result 00 and changes no output.
- R5: A 1.8 V request made while `sig18_en_o` is 0 first drops `card_clk_en_o`, then captures `dat_lvl_i`. The sequence continues only if the lines read 4'b0000. Any other value leads to the retry path.
- R6: After DAT reads low, `sig18_en_o` is set and the sequencer waits 5 ms before capturing the readback. A readback of 0 leads to the retry path.
- R7: After a readback of 1, `card_clk_en_o` returns to 1, the sequencer waits 1 ms, and it captures `dat_lvl_i`. A value of 4'b1111 finishes with result 00, 6·CYCLES_PER_MS+6 edges after the accepting edge. Any other value leads to the retry path.
- R8: The retry path drops `bus_pwr_o` for exactly 1 ms (CYCLES_PER_MS cycles). It then restores power, clears `sig18_en_o`, sets `card_clk_en_o`, and raises done with result 10, CYCLES_PER_MS edges after the failing decision.
- R9: `busy_o` is high from the accepting edge until done. `done_o` is a one-cycle pulse. `result_o` keeps its value after done. A start seen while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request pulse, taken only when idle |
| req_18v_i | input | 1 | Requested level: 1 = 1.8 V, 0 = 3.3 V |
| ver3_i | input | 1 | Controller version is 3.00 or above |
| sig18_rb_i | input | 1 | Regulator readback of the 1.8 V enable |
| dat_lvl_i | input | DAT_W | DAT line levels |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 2 | 00 success, 01 I/O error, 10 retry |
| sig18_en_o | output | 1 | 1.8 V signal enable |
| card_clk_en_o | output | 1 | Card clock enable |
| bus_pwr_o | output | 1 | Bus power |

## Verification
Each path's latency is measured in edges, so a design that sampled before the wait had fully run, or skipped the capture stage, arrives early and is caught. The regulator model lets the readback lag the enable, or sticks it at 0 or at 1. This exposes a design that reads the enable it drives instead of the readback, or that swaps the error and retry codes.

DAT patterns with a single wrong line, both before and after the clock restart, catch decisions that test only part of the lines. The power-low window is counted in cycles. Starting a second request mid-sequence shows whether a design would restart or gate the clock by mistake.

// File: rtl/vsw_pkg.sv
package vsw_pkg;

  typedef enum logic [1:0] {
    RES_OK    = 2'b00,
    RES_IOERR = 2'b01,
    RES_RETRY = 2'b10
  } vsw_res_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_HI_WAIT,
    S_HI_CAP,
    S_HI_CHK,
    S_LO_CAP0,
    S_LO_CHK0,
    S_LO_WAIT5,
    S_LO_CAP1,
    S_LO_CHK1,
    S_LO_WAIT1,
    S_LO_CAP2,
    S_LO_CHK2,
    S_PWR_WAIT
  } vsw_state_e;

endpackage

// File: rtl/vsw_interval_timer.sv
module vsw_interval_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             expire_o
);

  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  assign expire_o = run_q && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
      run_q <= 1'b1;
    end else if (run_q) begin
      if (cnt_q == '0) run_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  // an interval ends once; it never re-fires without a new load
  assert_timer_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_o && !load_i) |=> !expire_o);

endmodule

// File: rtl/vsw_line_sampler.sv
module vsw_line_sampler #(
  parameter int DAT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_i,
  input  logic [DAT_W-1:0] dat_i,
  input  logic             rb_i,
  output logic             all_low_o,
  output logic             all_high_o,
  output logic             rb_q_o
);

  logic [DAT_W-1:0] dat_q;
  logic             rb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dat_q <= '0;
      rb_q  <= 1'b0;
    end else if (cap_i) begin
      dat_q <= dat_i;
      rb_q  <= rb_i;
    end
  end

  assign all_low_o  = (dat_q == '0);
  assign all_high_o = &dat_q;
  assign rb_q_o     = rb_q;

endmodule

// File: rtl/vsw_fsm.sv
module vsw_fsm
  import vsw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       req_18v_i,
  input  logic       ver3_i,
  input  logic       expire_i,
  input  logic       dat_low_i,
  input  logic       dat_high_i,
  input  logic       rb_i,
  output logic       load_o,
  output logic       long_o,
  output logic       cap_o,
  output logic       sig18_o,
  output logic       clk_en_o,
  output logic       pwr_o,
  output logic       busy_o,
  output logic       done_o,
  output logic [1:0] result_o
);

  vsw_state_e state_q, state_n;
  logic       sig18_q, sig18_n;
  logic       clk_q, clk_n;
  logic       pwr_q, pwr_n;
  logic       done_q, done_n;
  vsw_res_e   res_q, res_n;
  logic       fail;

  always_comb begin
    state_n = state_q;
    sig18_n = sig18_q;
    clk_n   = clk_q;
    pwr_n   = pwr_q;
    done_n  = 1'b0;
    res_n   = res_q;
    load_o  = 1'b0;
    long_o  = 1'b0;
    cap_o   = 1'b0;
    fail    = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (start_i) begin
          if (!ver3_i || (req_18v_i && sig18_q)) begin
            done_n = 1'b1;
            res_n  = RES_OK;
          end else if (req_18v_i) begin
            clk_n   = 1'b0;
            state_n = S_LO_CAP0;
          end else begin
            sig18_n = 1'b0;
            load_o  = 1'b1;
            long_o  = 1'b1;
            state_n = S_HI_WAIT;
          end
        end
      end
      S_HI_WAIT: if (expire_i) state_n = S_HI_CAP;
      S_HI_CAP: begin
        cap_o   = 1'b1;
        state_n = S_HI_CHK;
      end
      S_HI_CHK: begin
        done_n  = 1'b1;
        res_n   = rb_i ? RES_IOERR : RES_OK;
        state_n = S_IDLE;
      end
      S_LO_CAP0: begin
        cap_o   = 1'b1;
        state_n = S_LO_CHK0;
      end
      S_LO_CHK0: begin
        if (dat_low_i) begin
          sig18_n = 1'b1;
          load_o  = 1'b1;
          long_o  = 1'b1;
          state_n = S_LO_WAIT5;
        end else begin
          fail = 1'b1;
        end
      end
      S_LO_WAIT5: if (expire_i) state_n = S_LO_CAP1;
      S_LO_CAP1: begin
        cap_o   = 1'b1;
        state_n = S_LO_CHK1;
      end
      S_LO_CHK1: begin
        if (rb_i) begin
          clk_n   = 1'b1;
          load_o  = 1'b1;
          state_n = S_LO_WAIT1;
        end else begin
          fail = 1'b1;
        end
      end
      S_LO_WAIT1: if (expire_i) state_n = S_LO_CAP2;
      S_LO_CAP2: begin
        cap_o   = 1'b1;
        state_n = S_LO_CHK2;
      end
      S_LO_CHK2: begin
        if (dat_high_i) begin
          done_n  = 1'b1;
          res_n   = RES_OK;
          state_n = S_IDLE;
        end else begin
          fail = 1'b1;
        end
      end
      S_PWR_WAIT: begin
        if (expire_i) begin
          pwr_n   = 1'b1;
          sig18_n = 1'b0;
          clk_n   = 1'b1;
          done_n  = 1'b1;
          res_n   = RES_RETRY;
          state_n = S_IDLE;
        end
      end
      default: state_n = S_IDLE;
    endcase
    if (fail) begin
      pwr_n   = 1'b0;
      load_o  = 1'b1;
      long_o  = 1'b0;
      state_n = S_PWR_WAIT;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      sig18_q <= 1'b0;
      clk_q   <= 1'b1;
      pwr_q   <= 1'b1;
      done_q  <= 1'b0;
      res_q   <= RES_OK;
    end else begin
      state_q <= state_n;
      sig18_q <= sig18_n;
      clk_q   <= clk_n;
      pwr_q   <= pwr_n;
      done_q  <= done_n;
      res_q   <= res_n;
    end
  end

  assign sig18_o  = sig18_q;
  assign clk_en_o = clk_q;
  assign pwr_o    = pwr_q;
  assign busy_o   = (state_q != S_IDLE);
  assign done_o   = done_q;
  assign result_o = res_q;

  assert_ver_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_IDLE && start_i && !ver3_i) |=>
      (done_q && res_q == RES_OK && $stable(sig18_q) && $stable(clk_q) && $stable(pwr_q)));

  assert_clk_off_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_q |-> busy_o);

  assert_sig18_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sig18_q) |-> ($past(state_q) == S_LO_CHK0 && $past(dat_low_i)));

  assert_pwr_off_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_q |-> (state_q == S_PWR_WAIT));

  assert_retry_restore_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && res_q == RES_RETRY) |-> (pwr_q && clk_q && !sig18_q));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  assert_result_legal_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (res_q != 2'b11));

endmodule

// File: rtl/vsw_sequencer.sv
module vsw_sequencer #(
  parameter int CYCLES_PER_MS  = 1000,
  parameter int SWITCH_WAIT_MS = 5,
  parameter int SETTLE_WAIT_MS = 1,
  parameter int DAT_W          = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             req_18v_i,
  input  logic             ver3_i,
  input  logic             sig18_rb_i,
  input  logic [DAT_W-1:0] dat_lvl_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [1:0]       result_o,
  output logic             sig18_en_o,
  output logic             card_clk_en_o,
  output logic             bus_pwr_o
);

  localparam int LONG_CYC  = SWITCH_WAIT_MS * CYCLES_PER_MS;
  localparam int SHORT_CYC = SETTLE_WAIT_MS * CYCLES_PER_MS;
  localparam int MAX_CYC   = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
  localparam int CNT_W     = (MAX_CYC > 2) ? $clog2(MAX_CYC) : 1;
  localparam logic [CNT_W-1:0] LONG_VAL  = CNT_W'(LONG_CYC - 1);
  localparam logic [CNT_W-1:0] SHORT_VAL = CNT_W'(SHORT_CYC - 1);

  logic             load, long_sel, expire, cap;
  logic             dat_low, dat_high, rb_q;
  logic [CNT_W-1:0] load_val;

  assign load_val = long_sel ? LONG_VAL : SHORT_VAL;

  vsw_interval_timer #(.CNT_W(CNT_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load),
    .load_val_i (load_val),
    .expire_o   (expire)
  );

  vsw_line_sampler #(.DAT_W(DAT_W)) u_sampler (
    .clk        (clk),
    .rst_n      (rst_n),
    .cap_i      (cap),
    .dat_i      (dat_lvl_i),
    .rb_i       (sig18_rb_i),
    .all_low_o  (dat_low),
    .all_high_o (dat_high),
    .rb_q_o     (rb_q)
  );

  vsw_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .req_18v_i  (req_18v_i),
    .ver3_i     (ver3_i),
    .expire_i   (expire),
    .dat_low_i  (dat_low),
    .dat_high_i (dat_high),
    .rb_i       (rb_q),
    .load_o     (load),
    .long_o     (long_sel),
    .cap_o      (cap),
    .sig18_o    (sig18_en_o),
    .clk_en_o   (card_clk_en_o),
    .pwr_o      (bus_pwr_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .result_o   (result_o)
  );

endmodule

// File: tb/tb_vsw_sequencer.sv
module tb_vsw_sequencer;

  localparam int CPM = 4;

  logic       clk, rst_n;
  logic       start_i, req_18v_i, ver3_i, sig18_rb_i;
  logic [3:0] dat_lvl_i;
  logic       busy_o, done_o, sig18_en_o, card_clk_en_o, bus_pwr_o;
  logic [1:0] result_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [2:0] reg_sh;
  logic [1:0] rb_mode;  // 0 follow with 3-cycle lag, 1 stuck low, 2 stuck high

  vsw_sequencer #(.CYCLES_PER_MS(CPM)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .req_18v_i(req_18v_i),
    .ver3_i(ver3_i), .sig18_rb_i(sig18_rb_i), .dat_lvl_i(dat_lvl_i),
    .busy_o(busy_o), .done_o(done_o), .result_o(result_o),
    .sig18_en_o(sig18_en_o), .card_clk_en_o(card_clk_en_o), .bus_pwr_o(bus_pwr_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) reg_sh <= '0;
    else        reg_sh <= {reg_sh[1:0], sig18_en_o};

  assign sig18_rb_i = (rb_mode == 2'd1) ? 1'b0 : (rb_mode == 2'd2) ? 1'b1 : reg_sh[2];

  // {ver, req18, rb_mode[1:0], dat_before[3:0], dat_after[3:0], result[1:0], latency[7:0], sig18_after}
  localparam logic [22:0] VEC [11] = '{
    {1'b0, 1'b1, 2'd0, 4'h0, 4'hF, 2'b00, 8'd1,  1'b0},
    {1'b1, 1'b0, 2'd0, 4'h0, 4'hF, 2'b00, 8'd23, 1'b0},
    {1'b1, 1'b1, 2'd0, 4'h0, 4'hF, 2'b00, 8'd31, 1'b1},
    {1'b1, 1'b1, 2'd0, 4'h0, 4'hF, 2'b00, 8'd1,  1'b1},
    {1'b0, 1'b0, 2'd0, 4'h0, 4'hF, 2'b00, 8'd1,  1'b1},
    {1'b1, 1'b0, 2'd2, 4'h0, 4'hF, 2'b01, 8'd23, 1'b0},
    {1'b1, 1'b1, 2'd0, 4'h4, 4'hF, 2'b10, 8'd7,  1'b0},
    {1'b1, 1'b1, 2'd1, 4'h0, 4'hF, 2'b10, 8'd29, 1'b0},
    {1'b1, 1'b1, 2'd0, 4'h0, 4'hE, 2'b10, 8'd35, 1'b0},
    {1'b1, 1'b1, 2'd0, 4'h0, 4'hF, 2'b00, 8'd31, 1'b1},
    {1'b1, 1'b0, 2'd0, 4'h0, 4'hF, 2'b00, 8'd23, 1'b0}
  };
  string vtag [11] = '{"R2", "R3", "R7", "R4", "R2", "R3", "R5", "R6", "R7", "R7", "R3"};

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // one request; returns latency (1 = done on accepting edge) and power-low cycles
  task automatic run_req(input logic ver, input logic lo, input logic [3:0] aft,
                         output int lat, output int pwr_low);
    bit saw_off = 0;
    @(negedge clk);
    start_i = 1'b1; req_18v_i = lo; ver3_i = ver;
    @(negedge clk);
    start_i = 1'b0;
    lat = 1; pwr_low = 0;
    while (!done_o && lat < 300) begin
      if (!bus_pwr_o) pwr_low++;
      if (!card_clk_en_o) saw_off = 1;
      if (saw_off && card_clk_en_o) dat_lvl_i = aft;
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int lat, pl;
    start_i = 0; req_18v_i = 0; ver3_i = 1; dat_lvl_i = 4'h0; rb_mode = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "sig18_en", sig18_en_o, 0);
    check("R1", "card_clk_en", card_clk_en_o, 1);
    check("R1", "bus_pwr", bus_pwr_o, 1);
    check("R1", "busy", busy_o, 0);
    check("R1", "done", done_o, 0);
    check("R1", "result", result_o, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < 11; i++) begin
      logic [22:0] v;
      v = VEC[i];
      rb_mode   = v[20:19];
      dat_lvl_i = v[18:15];
      run_req(v[22], v[21], v[14:11], lat, pl);
      check(vtag[i], "latency", lat, int'(v[8:1]));
      check(vtag[i], "result", result_o, int'(v[10:9]));
      check(vtag[i], "sig18_en after", sig18_en_o, int'(v[0]));
      check("R8", "power-low cycles", pl, (v[10:9] == 2'b10) ? CPM : 0);
      check(vtag[i], "clock on after", card_clk_en_o, 1);
      check(vtag[i], "power on after", bus_pwr_o, 1);
      @(negedge clk);
      check("R9", "done pulse width", done_o, 0);
      check("R9", "result held", result_o, int'(v[10:9]));
      rb_mode = 0;
      repeat (4) @(negedge clk);
    end

    // R9: start while busy is ignored
    @(negedge clk);
    start_i = 1; req_18v_i = 0; ver3_i = 1;
    @(negedge clk);
    start_i = 0;
    repeat (4) @(negedge clk);
    check("R9", "busy mid-sequence", busy_o, 1);
    start_i = 1; req_18v_i = 1;
    @(negedge clk);
    start_i = 0;
    lat = 6; pl = 0;
    while (!done_o && lat < 300) begin
      if (!card_clk_en_o) pl++;
      @(negedge clk);
      lat++;
    end
    check("R9", "latency with ignored start", lat, 23);
    check("R9", "clock never gated", pl, 0);
    check("R9", "sig18 untouched", sig18_en_o, 0);
    check("R9", "busy at done", busy_o, 0);

    // R1: reset in mid-sequence returns outputs to their reset levels
    dat_lvl_i = 4'h0;
    @(negedge clk);
    start_i = 1; req_18v_i = 1; ver3_i = 1;
    @(negedge clk);
    start_i = 0;
    repeat (8) @(negedge clk);
    check("R1", "sig18 set before reset", sig18_en_o, 1);
    rst_n = 0;
    @(negedge clk);
    check("R1", "sig18 after mid reset", sig18_en_o, 0);
    check("R1", "clock after mid reset", card_clk_en_o, 1);
    check("R1", "busy after mid reset", busy_o, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule